// File: doc/BRIEF.md
# Chained-Rule Frame Byte Classifier

The block inspects a received frame one byte per cycle against a small table of rules. Each rule tests a single byte under a mask. It also tests a running "last hit" value, under a second mask, against a predecessor rule number that the rule stores. This lets single-byte rules form chains that recognise multi-byte fields, such as a destination MAC address. For each byte, the winning rule supplies an action code, an interrupt flag and a match-control decision. The decision either keeps matching, closes the frame as finished, or closes it as discarded. The block only reports the action. Whatever the action causes happens elsewhere.

Software reaches the table one rule at a time. It first writes a rule number into an address register. It then reads or writes that rule through a match register and a control register. A filter stays disabled while its first-byte rule has a zero hit mask, so software enables the filter last, once the whole chain is in place. On the same byte stream, the block also reports whether the two-byte field at bytes 12 and 13 of the frame is a type or a length.

Top module: `cam_frame_classifier`

## Requirements
- R1: A rule matches a byte only when its hit mask is nonzero, (byte XOR data) AND data-mask is zero, and (last-hit XOR predecessor) AND hit-mask is zero. A rule with a zero hit mask never matches.
- R2: Rules are numbered 1..NUM_RULES. On a byte with `byte_sof_i` set, the last-hit value is 0. After a winning rule, the last-hit value is that rule's number. A rule with predecessor 0 and hit mask 0x7F therefore matches only the first byte of a frame.
- R3: When several rules match the same byte, the lowest-numbered rule wins.
- R4: If no rule matches a byte, the outputs show `res_hit_o`=0, `res_rule_o`=0x7F, and action, irq, done and drop all 0. No later byte of that frame matches any rule until the next `byte_sof_i`.
- R5: Match control is 0 = continue, 1 = finish, 2 = discard (3 acts as continue). Finish raises `res_done_o` and discard raises `res_drop_o`. Both end matching for the rest of the frame, and the two are never high together.
- R6: For every byte accepted in cycle t, `res_valid_o` is high in cycle t+1 and carries the number, action code and irq flag of the winning rule. When no byte is accepted, `res_valid_o` is low in the following cycle.
- R7: `reg_sel_i` 0 selects the address register (bits 6:0, rule number). `reg_sel_i` 1 selects the match register: predecessor at bits 6:0, hit mask at 14:8, data at 23:16, data mask at 31:24. `reg_sel_i` 2 selects the control register: action at 4:0, irq at bit 5, match control at 7:6. `reg_rdata_o` shows the selected register combinationally. With rule number 0 or a number above NUM_RULES, match and control writes are ignored and read as 0.
- R8: After reset every rule is zero and disabled, except rule NUM_RULES. That rule is promiscuous: predecessor 0, hit mask 0x7F, data mask 0, action 0x11, irq 0, finish. Every frame's first byte therefore hits it.
- R9: On frame byte index 13, `lt_valid_o` pulses with the R6 timing. `lt_type_o` is 1 when {byte 12, byte 13} >= 0x0600, and 0 otherwise. On any other index, `lt_valid_o` is 0.
- R10: A table write in the same cycle as a byte leaves that byte classified by the old rule contents. The new contents apply from the next byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| byte_valid_i | input | 1 | A frame byte is present |
| byte_sof_i | input | 1 | Byte is the first of its frame |
| byte_data_i | input | 8 | Frame byte |
| reg_sel_i | input | 2 | Host register select |
| reg_we_i | input | 1 | Host write strobe |
| reg_wdata_i | input | 32 | Host write data |
| reg_rdata_o | output | 32 | Host read data of the selected register |
| res_valid_o | output | 1 | Result for the previous cycle's byte |
| res_hit_o | output | 1 | A rule matched |
| res_rule_o | output | 7 | Winning rule number, 0x7F on no match |
| res_action_o | output | 5 | Action code of the winning rule |
| res_irq_o | output | 1 | Interrupt flag of the winning rule |
| res_done_o | output | 1 | Winning rule finishes the frame |
| res_drop_o | output | 1 | Winning rule discards the frame |
| lt_valid_o | output | 1 | Length/type verdict available |
| lt_type_o | output | 1 | Field at bytes 12-13 is a type |

## Verification
A host write to a rule can land in the same cycle that a frame byte is being compared against that same rule. The bench provokes this by driving a first-of-frame byte together with a control-register write to the only rule that should win. It then judges that the result carries the old action code, and that the next frame's first byte carries the new one. A second collision happens when the lowest-numbered filter rule and the promiscuous default both match one byte. Here the bench checks that the lower number wins, and that the default takes the byte once the filter is disabled.

// File: rtl/cls_pkg.sv
package cls_pkg;
  localparam int HIT_W  = 7;
  localparam int BYTE_W = 8;
  localparam int ACT_W  = 5;
  localparam logic [HIT_W-1:0] NO_HIT = '1;
  localparam logic [ACT_W-1:0] ACT_ACCEPT = 5'h11;
  localparam int LT_HI_IDX = 12;

  typedef enum logic [1:0] {
    MC_MORE = 2'd0,
    MC_DONE = 2'd1,
    MC_DROP = 2'd2,
    MC_RSVD = 2'd3
  } mctl_e;

  typedef enum logic [1:0] {
    SEL_ADDR  = 2'd0,
    SEL_MATCH = 2'd1,
    SEL_CTL   = 2'd2,
    SEL_NONE  = 2'd3
  } sel_e;

  typedef struct packed {
    logic [HIT_W-1:0]  pval;
    logic [HIT_W-1:0]  pmask;
    logic [BYTE_W-1:0] data;
    logic [BYTE_W-1:0] dmask;
    logic [ACT_W-1:0]  act;
    logic              irq;
    mctl_e             mc;
  } rule_t;

  function automatic rule_t reset_rule(input logic promisc);
    rule_t r;
    r = '0;
    if (promisc) begin
      r.pmask = '1;
      r.act   = ACT_ACCEPT;
      r.mc    = MC_DONE;
    end
    return r;
  endfunction
endpackage

// File: rtl/cls_rule_table.sv
module cls_rule_table
  import cls_pkg::*;
#(
  parameter int NUM_RULES = 16
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [1:0]                  reg_sel_i,
  input  logic                        reg_we_i,
  input  logic [31:0]                 reg_wdata_i,
  output logic [31:0]                 reg_rdata_o,
  output rule_t [NUM_RULES-1:0]       rules_o
);
  logic [HIT_W-1:0] addr_q;
  rule_t            cur;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) addr_q <= '0;
    else if (reg_we_i && reg_sel_i == SEL_ADDR) addr_q <= reg_wdata_i[HIT_W-1:0];
  end

  for (genvar g = 0; g < NUM_RULES; g++) begin : g_rule
    localparam logic [HIT_W-1:0] NUM = HIT_W'(g + 1);
    localparam logic PROMISC = (g == NUM_RULES - 1);
    logic hit_addr;
    assign hit_addr = (addr_q == NUM);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        rules_o[g] <= reset_rule(PROMISC);
      end else if (reg_we_i && hit_addr) begin
        if (reg_sel_i == SEL_MATCH) begin
          rules_o[g].pval  <= reg_wdata_i[HIT_W-1:0];
          rules_o[g].pmask <= reg_wdata_i[8 +: HIT_W];
          rules_o[g].data  <= reg_wdata_i[16 +: BYTE_W];
          rules_o[g].dmask <= reg_wdata_i[24 +: BYTE_W];
        end else if (reg_sel_i == SEL_CTL) begin
          rules_o[g].act <= reg_wdata_i[ACT_W-1:0];
          rules_o[g].irq <= reg_wdata_i[5];
          rules_o[g].mc  <= mctl_e'(reg_wdata_i[7:6]);
        end
      end
    end
  end

  // out-of-range address selects nothing and reads zero
  always_comb begin
    cur = '0;
    for (int i = 0; i < NUM_RULES; i++)
      if (addr_q == HIT_W'(i + 1)) cur = rules_o[i];
  end

  always_comb begin
    unique case (sel_e'(reg_sel_i))
      SEL_ADDR:  reg_rdata_o = {{(32-HIT_W){1'b0}}, addr_q};
      SEL_MATCH: reg_rdata_o = {cur.dmask, cur.data, 1'b0, cur.pmask, 1'b0, cur.pval};
      SEL_CTL:   reg_rdata_o = {24'b0, cur.mc, cur.irq, cur.act};
      default:   reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/cls_match_array.sv
module cls_match_array
  import cls_pkg::*;
#(
  parameter int NUM_RULES = 16
) (
  input  rule_t [NUM_RULES-1:0] rules_i,
  input  logic [BYTE_W-1:0]     byte_i,
  input  logic [HIT_W-1:0]      last_hit_i,
  input  logic                  armed_i,
  output logic                  hit_o,
  output logic [HIT_W-1:0]      win_num_o,
  output rule_t                 win_rule_o
);
  logic [NUM_RULES-1:0] match;

  for (genvar g = 0; g < NUM_RULES; g++) begin : g_cmp
    logic en, d_ok, p_ok;
    assign en   = |rules_i[g].pmask;
    assign d_ok = ~|((byte_i ^ rules_i[g].data) & rules_i[g].dmask);
    assign p_ok = ~|((last_hit_i ^ rules_i[g].pval) & rules_i[g].pmask);
    assign match[g] = armed_i && en && d_ok && p_ok;
  end

  // descending scan: lowest-numbered match is written last
  always_comb begin
    win_num_o  = NO_HIT;
    win_rule_o = '0;
    for (int i = NUM_RULES - 1; i >= 0; i--) begin
      if (match[i]) begin
        win_num_o  = HIT_W'(i + 1);
        win_rule_o = rules_i[i];
      end
    end
  end

  assign hit_o = |match;
endmodule

// File: rtl/cls_lentype.sv
module cls_lentype
  import cls_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              sof_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic              lt_valid_o,
  output logic              lt_type_o
);
  localparam logic [IDX_W-1:0] IDX_HI  = IDX_W'(LT_HI_IDX);
  localparam logic [IDX_W-1:0] IDX_LO  = IDX_W'(LT_HI_IDX + 1);
  localparam logic [IDX_W-1:0] IDX_SAT = '1;
  localparam logic [15:0]      TYPE_MIN = 16'h0600;

  logic [IDX_W-1:0]  idx_q, idx;
  logic [BYTE_W-1:0] hi_q;

  assign idx = sof_i ? '0 : idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q      <= IDX_SAT;
      hi_q       <= '0;
      lt_valid_o <= 1'b0;
      lt_type_o  <= 1'b0;
    end else begin
      lt_valid_o <= valid_i && (idx == IDX_LO);
      if (valid_i) begin
        if (idx != IDX_SAT) idx_q <= idx + 1'b1;
        else                idx_q <= idx;
        if (idx == IDX_HI) hi_q <= byte_i;
        if (idx == IDX_LO) lt_type_o <= ({hi_q, byte_i} >= TYPE_MIN);
      end
    end
  end
endmodule

// File: rtl/cam_frame_classifier.sv
module cam_frame_classifier
  import cls_pkg::*;
#(
  parameter int NUM_RULES = 16
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        byte_valid_i,
  input  logic        byte_sof_i,
  input  logic [7:0]  byte_data_i,
  input  logic [1:0]  reg_sel_i,
  input  logic        reg_we_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  output logic        res_valid_o,
  output logic        res_hit_o,
  output logic [6:0]  res_rule_o,
  output logic [4:0]  res_action_o,
  output logic        res_irq_o,
  output logic        res_done_o,
  output logic        res_drop_o,
  output logic        lt_valid_o,
  output logic        lt_type_o
);
  rule_t [NUM_RULES-1:0] rules;
  logic [HIT_W-1:0]      hit_q, last_hit, win_num;
  logic                  armed_q, armed, hit;
  rule_t                 win;
  logic                  keep_going;

  cls_rule_table #(.NUM_RULES(NUM_RULES)) i_table (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .reg_sel_i   (reg_sel_i),
    .reg_we_i    (reg_we_i),
    .reg_wdata_i (reg_wdata_i),
    .reg_rdata_o (reg_rdata_o),
    .rules_o     (rules)
  );

  assign last_hit = byte_sof_i ? '0 : hit_q;
  assign armed    = byte_sof_i | armed_q;

  cls_match_array #(.NUM_RULES(NUM_RULES)) i_match (
    .rules_i    (rules),
    .byte_i     (byte_data_i),
    .last_hit_i (last_hit),
    .armed_i    (armed),
    .hit_o      (hit),
    .win_num_o  (win_num),
    .win_rule_o (win)
  );

  assign keep_going = hit && (win.mc == MC_MORE || win.mc == MC_RSVD);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hit_q        <= NO_HIT;
      armed_q      <= 1'b0;
      res_valid_o  <= 1'b0;
      res_hit_o    <= 1'b0;
      res_rule_o   <= NO_HIT;
      res_action_o <= '0;
      res_irq_o    <= 1'b0;
      res_done_o   <= 1'b0;
      res_drop_o   <= 1'b0;
    end else begin
      res_valid_o <= byte_valid_i;
      res_hit_o   <= byte_valid_i && hit;
      res_done_o  <= byte_valid_i && hit && win.mc == MC_DONE;
      res_drop_o  <= byte_valid_i && hit && win.mc == MC_DROP;
      if (byte_valid_i) begin
        hit_q        <= win_num;
        armed_q      <= keep_going;
        res_rule_o   <= win_num;
        res_action_o <= win.act;
        res_irq_o    <= win.irq;
      end
    end
  end

  cls_lentype i_lentype (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .valid_i    (byte_valid_i),
    .sof_i      (byte_sof_i),
    .byte_i     (byte_data_i),
    .lt_valid_o (lt_valid_o),
    .lt_type_o  (lt_type_o)
  );
endmodule

// File: rtl/cls_checker.sv
module cls_checker #(
  parameter int NUM_RULES = 16
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        byte_valid_i,
  input logic        byte_sof_i,
  input logic [1:0]  reg_sel_i,
  input logic        reg_we_i,
  input logic [31:0] reg_wdata_i,
  input logic [31:0] reg_rdata_o,
  input logic        res_valid_o,
  input logic        res_hit_o,
  input logic [6:0]  res_rule_o,
  input logic [4:0]  res_action_o,
  input logic        res_irq_o,
  input logic        res_done_o,
  input logic        res_drop_o,
  input logic        lt_valid_o
);
  logic closed_q, closed_now;
  assign closed_now = (res_valid_o && (res_done_o || res_drop_o || !res_hit_o)) || closed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) closed_q <= 1'b1;
    else if (byte_valid_i && byte_sof_i) closed_q <= 1'b0;
    else closed_q <= closed_now;
  end

  assert_res_follows_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_valid_i |=> res_valid_o);
  assert_res_idle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !byte_valid_i |=> !res_valid_o);
  assert_done_drop_excl_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({res_done_o, res_drop_o}));
  assert_miss_quiet_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && !res_hit_o) |->
      (res_rule_o == 7'h7F && res_action_o == '0 && !res_irq_o && !res_done_o && !res_drop_o));
  assert_closed_frame_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_valid_i && !byte_sof_i && closed_now) |=> !res_hit_o);
  assert_rule_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && res_hit_o) |-> (res_rule_o != '0 && 32'(res_rule_o) <= NUM_RULES));
  assert_lt_timing_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lt_valid_o |-> res_valid_o);
  assert_addr_readback_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_sel_i == 2'd0) |=>
      (reg_sel_i != 2'd0 || reg_rdata_o[6:0] == $past(reg_wdata_i[6:0])));
endmodule

bind cam_frame_classifier cls_checker #(.NUM_RULES(NUM_RULES)) i_cls_checker (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .byte_valid_i (byte_valid_i),
  .byte_sof_i   (byte_sof_i),
  .reg_sel_i    (reg_sel_i),
  .reg_we_i     (reg_we_i),
  .reg_wdata_i  (reg_wdata_i),
  .reg_rdata_o  (reg_rdata_o),
  .res_valid_o  (res_valid_o),
  .res_hit_o    (res_hit_o),
  .res_rule_o   (res_rule_o),
  .res_action_o (res_action_o),
  .res_irq_o    (res_irq_o),
  .res_done_o   (res_done_o),
  .res_drop_o   (res_drop_o),
  .lt_valid_o   (lt_valid_o)
);

// File: tb/test_cam_frame_classifier.sv
module test_cam_frame_classifier;
  localparam int NR = 16;
  localparam logic [1:0] MORE = 2'd0, DONE = 2'd1, DROP = 2'd2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic byte_valid = 1'b0, byte_sof = 1'b0;
  logic [7:0] byte_data = '0;
  logic [1:0] reg_sel = '0;
  logic reg_we = 1'b0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic res_valid, res_hit, res_irq, res_done, res_drop, lt_valid, lt_type;
  logic [6:0] res_rule;
  logic [4:0] res_action;
  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  cam_frame_classifier #(.NUM_RULES(NR)) i_cam_frame_classifier (
    .clk_i(clk), .rst_ni(rst_n),
    .byte_valid_i(byte_valid), .byte_sof_i(byte_sof), .byte_data_i(byte_data),
    .reg_sel_i(reg_sel), .reg_we_i(reg_we), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .res_valid_o(res_valid), .res_hit_o(res_hit), .res_rule_o(res_rule),
    .res_action_o(res_action), .res_irq_o(res_irq), .res_done_o(res_done),
    .res_drop_o(res_drop), .lt_valid_o(lt_valid), .lt_type_o(lt_type)
  );

  // {byte12, byte13, expect_type}
  localparam logic [16:0] LT_VEC [6] = '{
    {16'h0600, 1'b1}, {16'h05FF, 1'b0}, {16'h0800, 1'b1},
    {16'h0000, 1'b0}, {16'hFFFF, 1'b1}, {16'h05DC, 1'b0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic sof, input logic [7:0] d);
    byte_valid = 1'b1; byte_sof = sof; byte_data = d;
    @(negedge clk);
    byte_valid = 1'b0; byte_sof = 1'b0;
  endtask

  // packed result {valid, hit, rule, action, irq, done, drop}
  function automatic logic [16:0] res();
    return {res_valid, res_hit, res_rule, res_action, res_irq, res_done, res_drop};
  endfunction

  function automatic logic [16:0] exp_res(input logic hit, input logic [6:0] r,
      input logic [4:0] a, input logic irq, input logic dn, input logic dr);
    return {1'b1, hit, r, a, irq, dn, dr};
  endfunction

  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    reg_sel = sel; reg_we = 1'b1; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] sel, output logic [31:0] d);
    reg_sel = sel;
    #1;
    d = reg_rdata;
  endtask

  task automatic prog(input logic [6:0] num, input logic [6:0] pv, input logic [6:0] pm,
      input logic [7:0] dt, input logic [7:0] dm, input logic [4:0] a, input logic irq,
      input logic [1:0] mc);
    wr(2'd0, {25'b0, num});
    wr(2'd1, {dm, dt, 1'b0, pm, 1'b0, pv});
    wr(2'd2, {24'b0, mc, irq, a});
  endtask

  localparam logic [16:0] MISS = {1'b1, 1'b0, 7'h7F, 5'h00, 1'b0, 1'b0, 1'b0};

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // reset state
    check("R6 idle after reset", 32'(res_valid), 32'd0);
    rd(2'd0, d); check("R7 addr reset", d, 32'd0);
    wr(2'd0, 32'd16);
    rd(2'd1, d); check("R8 promisc match fields", d, 32'h00007F00);
    rd(2'd2, d); check("R8 promisc ctl fields", d, 32'h00000051);
    wr(2'd0, 32'd1);
    rd(2'd1, d); check("R8 rule1 cleared", d, 32'd0);

    // promiscuous default
    send(1'b1, 8'h12); check("R8 first byte hits default", 32'(res()), 32'(exp_res(1, 7'd16, 5'h11, 0, 1, 0)));
    send(1'b0, 8'h34); check("R5 done closes frame", 32'(res()), 32'(MISS));

    // length/type vectors walked by one loop
    for (int v = 0; v < 6; v++) begin
      for (int b = 0; b < 14; b++) begin
        logic [7:0] bt;
        bt = (b == 12) ? LT_VEC[v][16:9] : (b == 13) ? LT_VEC[v][8:1] : 8'(b);
        send(b == 0, bt);
        if (b == 12) check("R9 no verdict at byte 12", 32'(lt_valid), 32'd0);
        if (b == 13) begin
          check("R9 verdict valid", 32'(lt_valid), 32'd1);
          check("R9 type vs length", 32'(lt_type), 32'(LT_VEC[v][0]));
        end
      end
    end

    // chains
    prog(7'd1, 7'd0, 7'h7F, 8'hAA, 8'hFF, 5'h18, 1'b1, MORE);
    prog(7'd2, 7'd1, 7'h7F, 8'h55, 8'hFF, 5'h09, 1'b0, DONE);
    prog(7'd3, 7'd1, 7'h7F, 8'h66, 8'hFF, 5'h00, 1'b0, DROP);
    rd(2'd1, d); check("R7 match readback", d, 32'hFF667F01);
    rd(2'd2, d); check("R7 ctl readback", d, 32'h00000080);

    send(1'b1, 8'hAA); check("R3 lowest rule wins over default", 32'(res()), 32'(exp_res(1, 7'd1, 5'h18, 1, 0, 0)));
    send(1'b0, 8'h55); check("R2 chained second byte", 32'(res()), 32'(exp_res(1, 7'd2, 5'h09, 0, 1, 0)));
    send(1'b0, 8'h55); check("R5 no match after done", 32'(res()), 32'(MISS));
    send(1'b1, 8'hAB); check("R1 data mismatch falls to default", 32'(res()), 32'(exp_res(1, 7'd16, 5'h11, 0, 1, 0)));
    send(1'b1, 8'h55); check("R2 chained rule not on first byte", 32'(res()), 32'(exp_res(1, 7'd16, 5'h11, 0, 1, 0)));
    send(1'b1, 8'hAA);
    send(1'b0, 8'h56); check("R4 miss mid chain", 32'(res()), 32'(MISS));
    send(1'b0, 8'h55); check("R4 frame stays dead", 32'(res()), 32'(MISS));
    send(1'b1, 8'hAA);
    send(1'b0, 8'h66); check("R5 drop", 32'(res()), 32'(exp_res(1, 7'd3, 5'h00, 0, 0, 1)));
    send(1'b0, 8'hAA); check("R5 no match after drop", 32'(res()), 32'(MISS));

    // masked data byte
    prog(7'd4, 7'd0, 7'h7F, 8'h30, 8'hF0, 5'h0C, 1'b0, DONE);
    send(1'b1, 8'h3C); check("R1 masked data match", 32'(res()), 32'(exp_res(1, 7'd4, 5'h0C, 0, 1, 0)));
    send(1'b1, 8'h4C); check("R1 masked data miss", 32'(res()), 32'(exp_res(1, 7'd16, 5'h11, 0, 1, 0)));

    // disable via zero hit mask
    prog(7'd1, 7'd0, 7'h00, 8'hAA, 8'hFF, 5'h18, 1'b1, MORE);
    send(1'b1, 8'hAA); check("R1 zero hit mask disables", 32'(res()), 32'(exp_res(1, 7'd16, 5'h11, 0, 1, 0)));

    // table write colliding with a classified byte
    prog(7'd1, 7'd0, 7'h7F, 8'hAA, 8'hFF, 5'h18, 1'b1, MORE);
    byte_valid = 1'b1; byte_sof = 1'b1; byte_data = 8'hAA;
    reg_sel = 2'd2; reg_we = 1'b1; reg_wdata = {24'b0, MORE, 1'b1, 5'h05};
    @(negedge clk);
    byte_valid = 1'b0; byte_sof = 1'b0; reg_we = 1'b0;
    check("R10 old contents used", 32'(res_action), 32'h18);
    send(1'b1, 8'hAA); check("R10 new contents next byte", 32'(res_action), 32'h05);
    @(negedge clk);
    check("R6 no byte no result", 32'(res_valid), 32'd0);

    // out-of-range addresses
    wr(2'd0, 32'd0);
    wr(2'd1, 32'hDEADBEEF);
    rd(2'd1, d); check("R7 rule 0 reads zero", d, 32'd0);
    wr(2'd0, 32'd17);
    wr(2'd2, 32'h000000FF);
    rd(2'd0, d); check("R7 addr holds 17", d, 32'd17);
    rd(2'd2, d); check("R7 rule 17 reads zero", d, 32'd0);
    wr(2'd0, 32'd16);
    rd(2'd1, d); check("R7 default untouched by bad writes", d, 32'h00007F00);
    rd(2'd2, d); check("R7 default ctl untouched", d, 32'h00000051);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule